// File: doc/BRIEF.md
# Row-column thermometer cell-select decoder

This block converts a binary code into enable lines for a square matrix of unit cells, such as the current cells of a segmented converter. The code is split into an upper field that picks a row and a lower field that picks a column. Each field goes through its own binary-to-thermometer decoder. A small gate function in each cell combines its row and column lines to decide whether the cell is on.

Every cell has its own retiming flop, so all enables change together on the rising clock edge. The number of enabled cells equals the code sampled on the previous edge. Raising the code by one therefore switches exactly one extra cell on, and the count of enabled cells never falls as the code rises.

Top module: `cell_matrix_decoder`

## Requirements
- R1: One clock edge after `code_i` is sampled, `cell_en_o` holds a contiguous run of ones in bits [code-1:0] and zeros in all higher bits. Bit index = row*32 + column, where row = `code_i[9:5]` and column = `code_i[4:0]`.
- R2: The number of set bits in `cell_en_o` equals the sampled code. Code 0 enables no cell and code 1023 enables 1023 cells.
- R3: Row thermometer line k is high exactly when the row field is greater than k. Line 0 is the OR of the five row bits, line 30 is their AND, and line 31 is never high. At the ports, row k of the output is completely on exactly when the row field is greater than k.
- R4: Column thermometer line k is high exactly when the column field is greater than k, with the same OR, AND and never-high rules as the rows. At the ports, the active row has exactly column-field cells on.
- R5: Cell (r, c) is on exactly when r is less than the row field, or when r equals the row field and c is less than the column field.
- R6: When the code rises by one between successive samples, every cell that was on stays on and exactly one cell turns on.
- R7: `cell_en_o` changes only on a rising edge of `clk_i`. A change of `code_i` between edges leaves the output unchanged until the next edge.
- R8: While `rst_ni` is low, all enables are zero. The clear takes effect at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all enables update on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_i | input | 10 | Binary code: row field in [9:5], column field in [4:0] |
| cell_en_o | output | 1024 | Registered cell enables, index row*32+column |

## Verification
A wrong thermometer line or a wrong cell gate shows up one edge after the code that reaches it. The symptom is a gap in the run of ones, a wrong count, or a row that is full when it should be partial. An ascending and a descending sweep over every code reach every such line within about two thousand cycles. A flop that misses reset, or a path that bypasses a flop, shows up within one cycle: the output either differs from zero during reset or moves between clock edges.

// File: rtl/celldec_pkg.sv
package celldec_pkg;
  localparam int unsigned DEF_ROW_BITS = 5;
  localparam int unsigned DEF_COL_BITS = 5;

  // Gate-level select for one cell: on if row below active, or active row and column lit
  function automatic logic cell_select(input logic row_full, input logic row_here,
                                       input logic col_on);
    return ~(~row_full & ~(row_here & col_on));
  endfunction
endpackage

// File: rtl/therm_decoder.sv
module therm_decoder #(
  parameter int unsigned IN_BITS = 5,
  localparam int unsigned LINES = 1 << IN_BITS
) (
  input  logic [IN_BITS-1:0] bin_i,
  output logic [LINES-1:0]   therm_o
);
  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign therm_o[k] = (bin_i > IN_BITS'(k));
  end
endmodule

// File: rtl/cell_slice.sv
module cell_slice
  import celldec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic row_full_i,
  input  logic row_here_i,
  input  logic col_on_i,
  output logic en_o
);
  logic sel;
  assign sel = cell_select(row_full_i, row_here_i, col_on_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= 1'b0;
    else         en_o <= sel;
  end
endmodule

// File: rtl/cell_matrix_decoder.sv
module cell_matrix_decoder
  import celldec_pkg::*;
#(
  parameter int unsigned ROW_BITS = DEF_ROW_BITS,
  parameter int unsigned COL_BITS = DEF_COL_BITS,
  localparam int unsigned CODE_W = ROW_BITS + COL_BITS,
  localparam int unsigned ROWS = 1 << ROW_BITS,
  localparam int unsigned COLS = 1 << COL_BITS,
  localparam int unsigned NUM_CELLS = ROWS * COLS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CODE_W-1:0]    code_i,
  output logic [NUM_CELLS-1:0] cell_en_o
);
  logic [ROW_BITS-1:0] row_fld;
  logic [COL_BITS-1:0] col_fld;
  logic [ROWS-1:0]     row_th;
  logic [COLS-1:0]     col_th;
  logic [ROWS-1:0]     row_here;

  assign row_fld = code_i[CODE_W-1:COL_BITS];
  assign col_fld = code_i[COL_BITS-1:0];

  therm_decoder #(.IN_BITS(ROW_BITS)) u_row_dec (.bin_i(row_fld), .therm_o(row_th));
  therm_decoder #(.IN_BITS(COL_BITS)) u_col_dec (.bin_i(col_fld), .therm_o(col_th));

  // Active row: first row whose thermometer line is low
  for (genvar r = 0; r < ROWS; r++) begin : g_here
    if (r == 0) begin : g_first
      assign row_here[r] = ~row_th[r];
    end else begin : g_rest
      assign row_here[r] = ~row_th[r] & row_th[r-1];
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      cell_slice u_cell (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .row_full_i (row_th[r]),
        .row_here_i (row_here[r]),
        .col_on_i   (col_th[c]),
        .en_o       (cell_en_o[r*COLS + c])
      );
    end
  end
endmodule

// File: rtl/cell_matrix_checker.sv
module cell_matrix_checker #(
  parameter int unsigned ROW_BITS = 5,
  parameter int unsigned COL_BITS = 5,
  localparam int unsigned CODE_W = ROW_BITS + COL_BITS,
  localparam int unsigned ROWS = 1 << ROW_BITS,
  localparam int unsigned COLS = 1 << COL_BITS,
  localparam int unsigned NUM_CELLS = ROWS * COLS
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [CODE_W-1:0]    code_i,
  input logic [NUM_CELLS-1:0] cell_en_o,
  input logic [ROW_BITS-1:0]  row_fld,
  input logic [COL_BITS-1:0]  col_fld,
  input logic [ROWS-1:0]      row_th,
  input logic [COLS-1:0]      col_th
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_PREFIX_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((cell_en_o + 1'b1) & cell_en_o) == '0)) else $error("prefix shape"); // R1

  AST_COUNT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1) |-> ($countones(cell_en_o) == $past(code_i))) else $error("count"); // R2

  AST_ROW_LOW_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_th[0] == (|row_fld)) else $error("row low line"); // R3
  AST_ROW_TOP_AND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_th[ROWS-2] == (&row_fld)) else $error("row top line"); // R3
  AST_ROW_LAST_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_th[ROWS-1]) else $error("row last line"); // R3

  AST_COL_LOW_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_th[0] == (|col_fld)) else $error("col low line"); // R4
  AST_COL_TOP_AND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_th[COLS-2] == (&col_fld)) else $error("col top line"); // R4
  AST_COL_LAST_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !col_th[COLS-1]) else $error("col last line"); // R4

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q >= 2'd2) && ($past(code_i) == $past(code_i, 2) + 1)) |->
    (((cell_en_o & $past(cell_en_o)) == $past(cell_en_o)) &&
     ($countones(cell_en_o ^ $past(cell_en_o)) == 1))) else $error("step"); // R6

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (cell_en_o == '0) else $error("reset clear"); // R8
    end
  end
endmodule

bind cell_matrix_decoder cell_matrix_checker #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .code_i    (code_i),
  .cell_en_o (cell_en_o),
  .row_fld   (row_fld),
  .col_fld   (col_fld),
  .row_th    (row_th),
  .col_th    (col_th)
);

// File: tb/cell_matrix_decoder_bench.sv
module cell_matrix_decoder_bench;
  localparam int unsigned RB = 5;
  localparam int unsigned CB = 5;
  localparam int unsigned CW = RB + CB;
  localparam int unsigned NR = 1 << RB;
  localparam int unsigned NC = 1 << CB;
  localparam int unsigned NUM = NR * NC;
  localparam int unsigned MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [CW-1:0] code = '0;
  logic [NUM-1:0] en;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cell_matrix_decoder #(.ROW_BITS(RB), .COL_BITS(CB)) u_cell_matrix_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .code_i(code), .cell_en_o(en));

  task automatic check(input bit ok, input string tag, input logic [NUM-1:0] act,
                       input logic [NUM-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NUM-1:0] exp_vec(input int unsigned v);
    logic [NUM-1:0] one = 1;
    return (one << v) - 1'b1;
  endfunction

  task automatic full_rows(output int unsigned n);
    n = 0;
    for (int r = 0; r < NR; r++) if (&en[r*NC +: NC]) n++;
  endtask

  // Drive at a falling edge, verify hold before the rising edge, check after it
  task automatic apply(input int unsigned v, input logic [NUM-1:0] prev, input int unsigned prev_v);
    int unsigned fr, part, row, col;
    logic [NUM-1:0] e;
    @(negedge clk);
    code = CW'(v);
    #1;
    check(en == prev, "R7 hold between edges", en, prev);
    @(negedge clk);
    e = exp_vec(v);
    row = v >> CB;
    col = v % NC;
    check(en == e, "R1 vector", en, e);
    check($countones(en) == v, "R2 count", NUM'($countones(en)), NUM'(v));
    full_rows(fr);
    check(fr == row, "R3 full rows", NUM'(fr), NUM'(row));
    part = (row < NR) ? $countones(en[row*NC +: NC]) : 0;
    check(part == col, "R4 active row cells", NUM'(part), NUM'(col));
    check(en[(row*NC + col) % NUM] == 1'b0 && (v == 0 || en[v-1]), "R5 edge cell",
          en, e);
    if (v == prev_v + 1) begin
      check(((en & prev) == prev) && $countones(en ^ prev) == 1, "R6 one more cell",
            en, prev);
    end
  endtask

  initial begin
    logic [NUM-1:0] last;
    int unsigned last_v;
    repeat (3) @(negedge clk);
    check(en == '0, "R8 reset state", en, '0);
    rst_ni = 1'b1;
    last = '0;
    last_v = 0;
    for (int unsigned v = 0; v <= MAXC; v++) begin
      apply(v, last, last_v);
      last = exp_vec(v);
      last_v = v;
    end
    check($countones(en) == MAXC, "R2 max code", NUM'($countones(en)), NUM'(MAXC));
    for (int v = MAXC; v >= 0; v--) begin
      apply(v, last, 9999);
      last = exp_vec(v);
    end
    check(en == '0, "R2 zero code", en, '0);
    apply(700, last, 9999);
    @(negedge clk);
    #2 rst_ni = 1'b0;
    #1 check(en == '0, "R8 async clear", en, '0);
    repeat (2) @(negedge clk);
    check(en == '0, "R8 held in reset", en, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(en == exp_vec(700), "R1 after reset release", en, exp_vec(700));
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule